// File: doc/BRIEF.md
# Latch-Based Addressed Byte Memory

A four-entry store of bytes whose cells are level-sensitive transparent latches, not edge-triggered flops. One 2-bit address does two jobs: it steers the write (both the data lanes and the store level) to one word, and it picks which word drives the read bus. A one-to-four steering stage routes the incoming byte and the store level to the addressed word. Lanes that are not selected carry zeros and a low enable. A four-to-one multiplexer returns the addressed word.

While store is high, the addressed word is transparent. Its content follows the data input and the read bus shows that data as it passes through. When store drops, the word keeps the last value it saw. An active-low asynchronous reset clears every word to 0x00 and overrides store. The block has no clock. Callers must keep address and data steady around each store pulse.

Top module: `latch_byte_mem`

## Requirements
- R1: The read output always equals the stored content of the word selected by the 2-bit address (words 0 to 3), and it follows an address change with no store activity.
- R2: While store is high and reset is inactive, the addressed word is transparent. The read output equals the data input and tracks any change of it during the pulse.
- R3: After store falls, the addressed word holds the last data seen while store was high. Later data changes while store is low change neither the word nor the read output.
- R4: A store pulse writes only the addressed word. The other three words keep their contents, and exactly one word enable is active while store is high.
- R5: While rst_ni is low, all four words read 0x00, even with store high. After reset is released, every address reads 0x00 until it is written.
- R6: If the address changes while store is high, the write moves to the newly addressed word. The previously addressed word keeps the value it held when its enable dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low clear of all words |
| store_i | input | 1 | Store level; the addressed word is transparent while high |
| addr_i | input | 2 | Word select for both writing and reading |
| wdata_i | input | 8 | Write data byte |
| rd_data_o | output | 8 | Content of the addressed word |

## Verification
There is no clock, so the assertions are sampled on the falling edge of store and on the release of reset. They assume that address and data are steady at the instant store falls, and that reset is not released while store is high. The bench drives every input on a free-running pacing clock. It raises store only after address and data have settled, and it changes data after store has fallen. The single deliberate address change during a store pulse is made while store stays high, and it is checked only at the ports, after the pulse ends.

// File: rtl/lmem_pkg.sv
package lmem_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned WORDS_DEF  = 4;
endpackage

// File: rtl/lmem_latch_bit.sv
module lmem_latch_bit (
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  always_latch begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/lmem_word.sv
module lmem_word #(
  parameter int unsigned DW = 8
) (
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  // shared enable: all bits capture together
  for (genvar b = 0; b < DW; b++) begin : g_bit
    lmem_latch_bit u_bit (
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .d_i    (d_i[b]),
      .q_o    (q_o[b])
    );
  end
endmodule

// File: rtl/lmem_steer.sv
module lmem_steer #(
  parameter int unsigned DW = 8,
  parameter int unsigned NW = 4,
  localparam int unsigned AW = $clog2(NW)
) (
  input  logic [AW-1:0]        sel_i,
  input  logic                 en_i,
  input  logic [DW-1:0]        d_i,
  output logic [NW-1:0]        en_o,
  output logic [NW-1:0][DW-1:0] d_o
);
  // data and enable lanes come from one block so a latch never sees
  // its data lane zeroed before its enable drops
  always_comb begin
    en_o = '0;
    d_o  = '0;
    en_o[sel_i] = en_i;
    d_o[sel_i]  = d_i;
  end
endmodule

// File: rtl/lmem_rd_mux.sv
module lmem_rd_mux #(
  parameter int unsigned DW = 8,
  parameter int unsigned NW = 4,
  localparam int unsigned AW = $clog2(NW)
) (
  input  logic [AW-1:0]         sel_i,
  input  logic [NW-1:0][DW-1:0] words_i,
  output logic [DW-1:0]         q_o
);
  always_comb q_o = words_i[sel_i];
endmodule

// File: rtl/latch_byte_mem.sv
module latch_byte_mem #(
  parameter int unsigned DW = lmem_pkg::DATA_W_DEF,
  parameter int unsigned NW = lmem_pkg::WORDS_DEF,
  localparam int unsigned AW = $clog2(NW)
) (
  input  logic          rst_ni,
  input  logic          store_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rd_data_o
);
  logic [NW-1:0]         wr_en;
  logic [NW-1:0][DW-1:0] wr_lane;
  logic [NW-1:0][DW-1:0] words_q;

  lmem_steer #(.DW(DW), .NW(NW)) u_steer (
    .sel_i (addr_i),
    .en_i  (store_i),
    .d_i   (wdata_i),
    .en_o  (wr_en),
    .d_o   (wr_lane)
  );

  for (genvar w = 0; w < NW; w++) begin : g_word
    lmem_word #(.DW(DW)) u_word (
      .rst_ni (rst_ni),
      .en_i   (wr_en[w]),
      .d_i    (wr_lane[w]),
      .q_o    (words_q[w])
    );
  end

  lmem_rd_mux #(.DW(DW), .NW(NW)) u_rd (
    .sel_i   (addr_i),
    .words_i (words_q),
    .q_o     (rd_data_o)
  );
endmodule

// File: rtl/latch_byte_mem_chk.sv
module latch_byte_mem_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned NW = 4,
  localparam int unsigned AW = $clog2(NW)
) (
  input logic                  rst_ni,
  input logic                  store_i,
  input logic [AW-1:0]         addr_i,
  input logic [DW-1:0]         wdata_i,
  input logic [DW-1:0]         rd_data_o,
  input logic [NW-1:0]         wr_en,
  input logic [NW-1:0][DW-1:0] words_q
);
  // R1
  rd_sel_chk: assert property (@(negedge store_i) disable iff (!rst_ni)
    1'b1 |-> rd_data_o == words_q[addr_i]);

  // R2
  pass_through_chk: assert property (@(negedge store_i) disable iff (!rst_ni)
    1'b1 |-> rd_data_o == wdata_i);

  // R3
  capture_chk: assert property (@(negedge store_i) disable iff (!rst_ni)
    1'b1 |-> words_q[addr_i] == wdata_i);

  // R4
  one_enable_chk: assert property (@(negedge store_i) disable iff (!rst_ni)
    1'b1 |-> $countones(wr_en) == 1);

  // R5
  reset_clear_chk: assert property (@(posedge rst_ni)
    1'b1 |-> words_q == '0);
endmodule

bind latch_byte_mem latch_byte_mem_chk #(.DW(DW), .NW(NW)) u_chk (
  .rst_ni    (rst_ni),
  .store_i   (store_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rd_data_o (rd_data_o),
  .wr_en     (wr_en),
  .words_q   (words_q)
);

// File: tb/latch_byte_mem_test.sv
module latch_byte_mem_test;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       store_i;
  logic [1:0] addr_i;
  logic [7:0] wdata_i;
  logic [7:0] rd_data_o;
  logic [7:0] model [4];
  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  latch_byte_mem uut (
    .rst_ni    (rst_ni),
    .store_i   (store_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rd_data_o (rd_data_o)
  );

  // {addr, data}
  localparam logic [9:0] VEC [8] = '{
    {2'd0, 8'h3C}, {2'd1, 8'hA1}, {2'd2, 8'h5F}, {2'd3, 8'hC6},
    {2'd2, 8'h00}, {2'd0, 8'hFF}, {2'd3, 8'h81}, {2'd1, 8'h7E}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk) addr_i = 2'(k);
      @(negedge clk) chk(req, rd_data_o, model[k]);
    end
  endtask

  task automatic store_pulse(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk) begin addr_i = a; wdata_i = d; end
    @(posedge clk) store_i = 1'b1;
    @(negedge clk) chk("R2 pass-through", rd_data_o, d);
    @(posedge clk) store_i = 1'b0;
    model[a] = d;
    @(posedge clk) wdata_i = ~d;
    @(negedge clk) chk("R3 hold after fall", rd_data_o, d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; store_i = 1'b0; addr_i = 2'd0; wdata_i = 8'h00;
    for (int k = 0; k < 4; k++) model[k] = 8'h00;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    check_all("R5 reset state");

    // R1 R4: vector table walk
    for (int i = 0; i < 8; i++) begin
      store_pulse(VEC[i][9:8], VEC[i][7:0]);
      check_all("R4 other words kept / R1 read select");
    end

    // R3: data toggling with store low is ignored
    @(posedge clk) begin addr_i = 2'd2; wdata_i = 8'h99; end
    @(negedge clk) chk("R3 ignored while low", rd_data_o, model[2]);

    // R2: data changes mid-pulse, last value is kept
    @(posedge clk) begin addr_i = 2'd3; wdata_i = 8'h11; end
    @(posedge clk) store_i = 1'b1;
    @(negedge clk) chk("R2 track 1", rd_data_o, 8'h11);
    @(posedge clk) wdata_i = 8'h22;
    @(negedge clk) chk("R2 track 2", rd_data_o, 8'h22);
    @(posedge clk) store_i = 1'b0;
    model[3] = 8'h22;
    @(posedge clk) wdata_i = 8'h00;
    check_all("R3 last mid-pulse value");

    // R6: address moved while store high
    @(posedge clk) begin addr_i = 2'd1; wdata_i = 8'hA5; end
    @(posedge clk) store_i = 1'b1;
    @(negedge clk) chk("R6 first word pass", rd_data_o, 8'hA5);
    @(posedge clk) addr_i = 2'd2;
    @(negedge clk) chk("R6 new word pass", rd_data_o, 8'hA5);
    @(posedge clk) store_i = 1'b0;
    model[1] = 8'hA5;
    model[2] = 8'hA5;
    @(posedge clk) wdata_i = 8'h00;
    check_all("R6 both words after move");

    // R5: reset overrides store
    @(posedge clk) begin rst_ni = 1'b0; addr_i = 2'd3; wdata_i = 8'hFF; end
    @(posedge clk) store_i = 1'b1;
    @(negedge clk) chk("R5 reset beats store", rd_data_o, 8'h00);
    @(posedge clk) store_i = 1'b0;
    @(posedge clk) rst_ni = 1'b1;
    for (int k = 0; k < 4; k++) model[k] = 8'h00;
    check_all("R5 cleared after reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule